// File: doc/BRIEF.md
# Sampling Converter Serial Responder

This block is the device-side control logic of a sampling converter that is read over a three-wire serial link: an active-low chip select, a serial clock and one data output with a separate output enable that stands for the tri-state pin. The link's pins are oversampled by the chip's system clock. Their edges are found inside the block and drive two state machines.

The frame state machine has the states FR_IDLE, FR_SEND and FR_DRAIN. A chip-select fall moves it from FR_IDLE to FR_SEND. In FR_SEND it counts serial-clock falling and rising edges and shifts out the captured result. It moves from FR_SEND to FR_DRAIN on the sixteenth falling edge, when the output is released. A chip-select rise moves it from FR_SEND or FR_DRAIN back to FR_IDLE. The frame machine also tells the analog datapath when to hold and when to track.

The power state machine has the states PM_DOWN (shutdown), PM_WAKE (frame started from shutdown), PM_RUN (normal, idle) and PM_BUSY (frame started in normal mode). A chip-select fall moves it from PM_DOWN to PM_WAKE and from PM_RUN to PM_BUSY. On a chip-select rise it moves from PM_WAKE or PM_BUSY to PM_DOWN or PM_RUN, depending on how many falling edges the frame contained. It also produces a flag that marks whether the frame in progress carries a usable conversion. The 12-bit result arrives on a parallel port from the converter core.

Top module: `conv_link_responder`

## Requirements
- R1: One system clock after chip select is seen falling, the output enable is 1, the data output is 0 and the track output is 0 (hold).
- R2: The output enable goes to 0 one system clock after the 16th serial-clock falling edge of the frame, or after chip select rises, whichever comes first; later falling edges in the same frame do not re-enable it, and the data output is 0 whenever the enable is 0.
- R3: After falling edge n of a frame the data output shows: 0 for n = 1 and 2, result bit (14 − n) for n = 3 to 14, and 0 for n = 15; the result is captured at the chip-select fall, and later changes on the parallel port do not affect the word.
- R4: The track output returns to 1 one system clock after the 13th serial-clock rising edge of the frame, and also after chip select rises.
- R5: For a frame started in normal mode, a chip-select rise after 2 to 9 falling edges puts the block in shutdown (awake output 0).
- R6: For a frame started in normal mode, a chip-select rise after 0 or 1 falling edges leaves the mode unchanged.
- R7: For a frame started in normal mode, a chip-select rise after 10 or more falling edges keeps normal mode; the awake output changes only on chip-select rises.
- R8: For a frame started in shutdown, a chip-select rise after fewer than 10 falling edges returns to shutdown, and after 10 or more falling edges enters normal mode.
- R9: The conversion-valid output, updated at each chip-select fall, is 0 for the first frame after reset and for any frame started in shutdown or following a frame started in shutdown that did not reach 10 falling edges; it is 1 for frames that follow a frame ending in normal mode with at least 10 falling edges.
- R10: Serial-clock edges are ignored while chip select is high, and the edge counters restart at every chip-select fall.
- R11: After reset the enable, data and conversion-valid outputs are 0, track is 1, and the mode is the one given by the START_AWAKE parameter (shutdown by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock level |
| result_i | input | DATA_W | Parallel conversion result from the core |
| sdo_o | output | 1 | Serial data value |
| sdo_en_o | output | 1 | Serial data output enable (0 = high impedance) |
| track_o | output | 1 | 1 = sampler tracks the input, 0 = hold |
| awake_o | output | 1 | 1 = normal mode, 0 = shutdown or powering up |
| cnv_ok_o | output | 1 | Current frame carries a usable conversion |

## Verification
The hardest situations to reach are the mode decisions at the exact edge counts 2 and 10, and the wake-up path in which a frame started in shutdown is cut short and the block falls back to shutdown. The stimulus builds each frame from an exact number of serial-clock pulses and then raises chip select. In this way it walks the block through wake, abort at 9, wake at exactly 10, sleep at exactly 2 and normal aborts. At each step it tracks what the mode and the valid flag must be.

// File: rtl/conv_link_pkg.sv
package conv_link_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SEND,
        FR_DRAIN
    } fr_state_t;

    typedef enum logic [1:0] {
        PM_DOWN,
        PM_WAKE,
        PM_RUN,
        PM_BUSY
    } pm_state_t;

endpackage

// File: rtl/conv_link_edges.sv
module conv_link_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic sclk_fall_o,
    output logic sclk_rise_o
);

    logic cs_d_q;
    logic sclk_d_q;
    logic sel_steady;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d_q   <= 1'b1;
            sclk_d_q <= 1'b0;
        end else begin
            cs_d_q   <= cs_n_i;
            sclk_d_q <= sclk_i;
        end
    end

    // serial clock edges count only while chip select has been low for two samples
    assign sel_steady  = ~cs_n_i & ~cs_d_q;
    assign cs_fall_o   = cs_d_q & ~cs_n_i;
    assign cs_rise_o   = ~cs_d_q & cs_n_i;
    assign sclk_fall_o = sel_steady & sclk_d_q & ~sclk_i;
    assign sclk_rise_o = sel_steady & ~sclk_d_q & sclk_i;

endmodule

// File: rtl/conv_link_frame.sv
module conv_link_frame
    import conv_link_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 3,
    parameter int FRAME_EDGES = 16,
    parameter int TRACK_EDGE  = 13,
    localparam int CNT_W      = $clog2(FRAME_EDGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              sclk_fall_i,
    input  logic              sclk_rise_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              track_o,
    output logic [CNT_W-1:0]  fall_cnt_o
);

    localparam int PAD_W = FRAME_EDGES - LEAD_ZEROS - DATA_W;
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_EDGES - 1);
    localparam logic [CNT_W-1:0] TRACK_M1  = CNT_W'(TRACK_EDGE - 1);
    localparam logic [CNT_W-1:0] RISE_MAX  = CNT_W'(FRAME_EDGES);

    fr_state_t              st_q, st_d;
    logic [FRAME_EDGES-1:0] word_q;
    logic [FRAME_EDGES-1:0] word_load;
    logic [CNT_W-1:0]       fall_cnt_q;
    logic [CNT_W-1:0]       rise_cnt_q;
    logic                   en_q;
    logic                   track_q;

    // leading zeros sit above the result, pad bits below it
    assign word_load = FRAME_EDGES'(result_i) << PAD_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:  if (cs_fall_i) st_d = FR_SEND;
            FR_SEND: begin
                if (cs_rise_i)
                    st_d = FR_IDLE;
                else if (sclk_fall_i && fall_cnt_q == LAST_FALL)
                    st_d = FR_DRAIN;
            end
            FR_DRAIN: if (cs_rise_i) st_d = FR_IDLE;
            default:  st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q     <= '0;
            fall_cnt_q <= '0;
            rise_cnt_q <= '0;
            en_q       <= 1'b0;
            track_q    <= 1'b1;
        end else begin
            unique case (st_q)
                FR_IDLE: begin
                    if (cs_fall_i) begin
                        word_q     <= word_load;
                        fall_cnt_q <= '0;
                        rise_cnt_q <= '0;
                        en_q       <= 1'b1;
                        track_q    <= 1'b0;
                    end
                end
                FR_SEND, FR_DRAIN: begin
                    if (cs_rise_i) begin
                        en_q    <= 1'b0;
                        track_q <= 1'b1;
                    end else begin
                        if (sclk_fall_i && st_q == FR_SEND) begin
                            fall_cnt_q <= fall_cnt_q + 1'b1;
                            word_q     <= word_q << 1;
                            if (fall_cnt_q == LAST_FALL) en_q <= 1'b0;
                        end
                        if (sclk_rise_i && rise_cnt_q != RISE_MAX) begin
                            rise_cnt_q <= rise_cnt_q + 1'b1;
                            if (rise_cnt_q == TRACK_M1) track_q <= 1'b1;
                        end
                    end
                end
                default: en_q <= 1'b0;
            endcase
        end
    end

    assign sdo_o      = en_q & word_q[FRAME_EDGES-1];
    assign sdo_en_o   = en_q;
    assign track_o    = track_q;
    assign fall_cnt_o = fall_cnt_q;

    AST_FALL_OPENS: assert property (@(posedge clk) disable iff (!rst_n) cs_fall_i |=> (sdo_en_o && !track_o)); // R1
    AST_RISE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) cs_rise_i |=> (!sdo_en_o && track_o)); // R2
    AST_TRACK_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (sclk_rise_i && !cs_rise_i && rise_cnt_q == TRACK_M1) |=> track_o); // R4
    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n) (st_q == FR_IDLE && !cs_fall_i) |=> !sdo_en_o); // R10
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) fall_cnt_q <= CNT_W'(FRAME_EDGES)); // R2

endmodule

// File: rtl/conv_link_power.sv
module conv_link_power
    import conv_link_pkg::*;
#(
    parameter int   FRAME_EDGES = 16,
    parameter int   SLEEP_EDGE  = 2,
    parameter int   KEEP_EDGE   = 10,
    parameter logic START_AWAKE = 1'b0,
    localparam int  CNT_W       = $clog2(FRAME_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall_i,
    input  logic             cs_rise_i,
    input  logic [CNT_W-1:0] fall_cnt_i,
    output logic             awake_o,
    output logic             cnv_ok_o
);

    localparam logic [CNT_W-1:0] SLEEP_C = CNT_W'(SLEEP_EDGE);
    localparam logic [CNT_W-1:0] KEEP_C  = CNT_W'(KEEP_EDGE);
    localparam pm_state_t        PM_RST  = START_AWAKE ? PM_RUN : PM_DOWN;

    pm_state_t st_q, st_d;
    logic      early;
    logic      keep;
    logic      pend_q;
    logic      ok_q;

    assign early = fall_cnt_i < SLEEP_C;
    assign keep  = fall_cnt_i >= KEEP_C;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PM_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PM_DOWN: if (cs_fall_i) st_d = PM_WAKE;
            PM_WAKE: if (cs_rise_i) st_d = keep ? PM_RUN : PM_DOWN;
            PM_RUN:  if (cs_fall_i) st_d = PM_BUSY;
            PM_BUSY: begin
                if (cs_rise_i) begin
                    if (early || keep) st_d = PM_RUN;
                    else               st_d = PM_DOWN;
                end
            end
            default: st_d = PM_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            ok_q   <= 1'b0;
        end else begin
            if (cs_fall_i) ok_q <= ~pend_q;
            if (cs_rise_i) begin
                if (st_d == PM_DOWN) pend_q <= 1'b1;
                else if (keep)       pend_q <= 1'b0;
            end
        end
    end

    assign awake_o  = (st_q == PM_RUN) || (st_q == PM_BUSY);
    assign cnv_ok_o = ok_q;

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (cs_rise_i && st_q == PM_BUSY && !early && !keep) |=> !awake_o); // R5
    AST_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cs_rise_i && st_q == PM_BUSY && early) |=> awake_o); // R6
    AST_AWAKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cs_rise_i |=> $stable(awake_o)); // R7
    AST_WAKE_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (cs_rise_i && st_q == PM_WAKE && !keep) |=> !awake_o); // R8
    AST_DUMMY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (cs_fall_i && st_q == PM_DOWN) |=> !cnv_ok_o); // R9

endmodule

// File: rtl/conv_link_responder.sv
module conv_link_responder #(
    parameter int   DATA_W      = 12,
    parameter int   LEAD_ZEROS  = 3,
    parameter int   FRAME_EDGES = 16,
    parameter int   TRACK_EDGE  = 13,
    parameter int   SLEEP_EDGE  = 2,
    parameter int   KEEP_EDGE   = 10,
    parameter logic START_AWAKE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              track_o,
    output logic              awake_o,
    output logic              cnv_ok_o
);

    localparam int CNT_W = $clog2(FRAME_EDGES + 1);

    logic             cs_fall;
    logic             cs_rise;
    logic             sclk_fall;
    logic             sclk_rise;
    logic [CNT_W-1:0] fall_cnt;

    conv_link_edges u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .sclk_i      (sclk_i),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .sclk_fall_o (sclk_fall),
        .sclk_rise_o (sclk_rise)
    );

    conv_link_frame #(
        .DATA_W      (DATA_W),
        .LEAD_ZEROS  (LEAD_ZEROS),
        .FRAME_EDGES (FRAME_EDGES),
        .TRACK_EDGE  (TRACK_EDGE)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sclk_fall_i (sclk_fall),
        .sclk_rise_i (sclk_rise),
        .result_i    (result_i),
        .sdo_o       (sdo_o),
        .sdo_en_o    (sdo_en_o),
        .track_o     (track_o),
        .fall_cnt_o  (fall_cnt)
    );

    conv_link_power #(
        .FRAME_EDGES (FRAME_EDGES),
        .SLEEP_EDGE  (SLEEP_EDGE),
        .KEEP_EDGE   (KEEP_EDGE),
        .START_AWAKE (START_AWAKE)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall_i  (cs_fall),
        .cs_rise_i  (cs_rise),
        .fall_cnt_i (fall_cnt),
        .awake_o    (awake_o),
        .cnv_ok_o   (cnv_ok_o)
    );

endmodule

// File: tb/conv_link_responder_tb_top.sv
module conv_link_responder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] res = '0;
    logic        sdo, sdo_en, track, awake, cnv_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] v;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    logic        p_cs = 1'b1, p_s = 1'b0;
    logic        m_en = 1'b0, m_trk = 1'b1, m_awake = 1'b0, m_ok = 1'b0, m_pend = 1'b1;
    logic        m_fr_awake = 1'b0;
    logic [15:0] m_word = '0;
    int          m_nf = 0, m_nr = 0;

    always #2 clk = ~clk;

    conv_link_responder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sclk_i   (sclk),
        .result_i (res),
        .sdo_o    (sdo),
        .sdo_en_o (sdo_en),
        .track_o  (track),
        .awake_o  (awake),
        .cnv_ok_o (cnv_ok)
    );

    // monitor: compares outputs against queued expectations, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [4:0] act;
            e = sb_q.pop_front();
            act = {sdo_en, sdo, track, awake, cnv_ok};
            checks++;
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s: {en,sdo,trk,awake,ok} actual %b expected %b at %0t", e.tag, act, e.v, $time);
            end
        end
    end

    task automatic step(input logic c, input logic s, input string tag);
        logic m_sdo;
        @(negedge clk);
        cs_n = c;
        sclk = s;
        if (p_cs && !c) begin
            m_en = 1'b1; m_nf = 0; m_nr = 0; m_trk = 1'b0;
            m_word = {3'b000, res, 1'b0};
            m_ok = !m_pend;
            m_fr_awake = m_awake;
        end else if (!p_cs && c) begin
            m_en = 1'b0; m_trk = 1'b1;
            if (m_fr_awake) begin
                if (m_nf >= 2 && m_nf < 10) m_awake = 1'b0;
            end else if (m_nf >= 10) begin
                m_awake = 1'b1;
            end
            if (!m_awake) m_pend = 1'b1;
            else if (m_nf >= 10) m_pend = 1'b0;
        end else if (!p_cs && !c) begin
            if (p_s && !s && m_nf < 16) begin
                m_nf++;
                if (m_nf == 16) m_en = 1'b0;
            end
            if (!p_s && s && m_nr < 16) begin
                m_nr++;
                if (m_nr == 13) m_trk = 1'b1;
            end
        end
        p_cs = c;
        p_s = s;
        m_sdo = (m_en && m_nf < 16) ? m_word[15 - m_nf] : 1'b0;
        @(posedge clk);
        #1;
        sb_q.push_back('{{m_en, m_sdo, m_trk, m_awake, m_ok}, tag});
    endtask

    // one frame: chip select fall, nf serial clock pulses, chip select rise
    task automatic frame(input logic [11:0] d, input int nf, input string tag_fall, input string tag_end);
        res = d;
        step(1'b0, 1'b0, tag_fall);
        res = ~d; // R3: port changes after capture must not reach the word
        for (int i = 0; i < nf; i++) begin
            step(1'b0, 1'b1, "R4");
            step(1'b0, 1'b0, (i >= 15) ? "R2" : "R3");
        end
        step(1'b1, 1'b0, tag_end);
        step(1'b1, 1'b0, tag_end);
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1, "R10");
            step(1'b1, 1'b0, "R10");
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, "R11");
        step(1'b1, 1'b0, "R11");
        idle_clocks(3);                      // R10 edges while deselected
        frame(12'hA5C, 16, "R9", "R8");      // wake frame, dummy result, reaches normal
        frame(12'h3F1, 16, "R9", "R7");      // valid full frame
        frame(12'h800, 1,  "R1", "R6");      // early rise keeps normal
        frame(12'h001, 2,  "R1", "R5");      // rise at exactly 2 -> shutdown
        frame(12'hFFF, 9,  "R9", "R8");      // wake attempt cut at 9 -> shutdown
        frame(12'h555, 10, "R9", "R8");      // wake with exactly 10 -> normal
        frame(12'hAAA, 12, "R9", "R7");      // aborted word, stays normal
        frame(12'h123, 9,  "R1", "R5");      // rise at 9 -> shutdown
        frame(12'h456, 18, "R9", "R8");      // wake, extra pulses past 16
        frame(12'h000, 16, "R9", "R3");      // valid all-zero word
        idle_clocks(2);                      // R10 after activity
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule